// File: doc/BRIEF.md
# Horizontal Pairwise Add/Subtract Unit

This block is a 128-bit SIMD datapath stage. It reduces neighbouring element pairs inside each of two source vectors. Each pair is added or subtracted, and the results are packed into one output vector. Elements are 16-bit words or 32-bit doublewords. For words, a saturating mode clamps each pair result to the signed 16-bit range instead of letting it wrap.

The results from operand A fill the low half of the output and the results from operand B fill the high half. Within each half, pair results keep their source order. The result is registered: one cycle after an accepted request, the output valid rises together with the new data. When no request is presented, the previous result stays on the output.

Top module: `hpair_addsub`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` equals the value `req_valid` had at the previous rising clock edge.
- R3: When `req_valid` is low at a clock edge, `res_data` keeps its previous value.
- R4: Opcode bit 0 selects subtract (1) or add (0), bit 1 selects doublewords (1) or words (0), and bit 2 requests saturation (1). With opcode 3'b000, output word k (k = 0..3) is the sum of A words 2k and 2k+1 modulo 2^16. Output word k+4 is the same for B.
- R5: With opcode 3'b001, each output word is the even-indexed source word minus the odd-indexed one, modulo 2^16. The packing is the same as in R4.
- R6: With opcode 3'b010, output dword k (k = 0..1) is the sum of A dwords 2k and 2k+1 modulo 2^32. Output dword k+2 is the same for B.
- R7: With opcode 3'b011, each output dword is the even-indexed source dword minus the odd-indexed one, modulo 2^32. The packing is the same as in R6.
- R8: With opcodes 3'b100 (add) and 3'b101 (subtract), each word pair result is clamped to the range -32768..32767 instead of wrapping.
- R9: Opcodes 3'b110 and 3'b111 give exactly the wrapping doubleword results of 3'b010 and 3'b011.
- R10: Element 0 is in the least significant bits of every vector. A pair results occupy bits 63:0 of the output and B pair results occupy bits 127:64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe; loads the result register |
| req_op | input | 3 | Opcode: bit 0 subtract, bit 1 doubleword, bit 2 saturate |
| src_a | input | 128 | Operand A; its pair results go to the low half |
| src_b | input | 128 | Operand B; its pair results go to the high half |
| res_valid | output | 1 | Result valid, one cycle after `req_valid` |
| res_data | output | 128 | Packed pair results |

## Verification
The hardest cases to reach are the clamp edges. Uniform random operands seldom land on a word pair whose exact sum or difference falls just outside the signed 16-bit range. They seldom produce a result that sits exactly on -32768 or 32767 without overflowing. Directed vectors therefore place 0x7FFF+1, 0x8000-1, 0x8000+0x8000 and exact-limit pairs in single lanes. The random phase draws each word from a small set of extreme values half of the time. All of this is repeated under the doubleword-with-saturate opcodes, so that a clamp leaking into 32-bit lanes would show.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
   localparam int OP_W       = 3;
   localparam int OP_SUB_BIT = 0;   // 1: even minus odd
   localparam int OP_DW_BIT  = 1;   // 1: 32-bit elements
   localparam int OP_SAT_BIT = 2;   // 1: clamp (16-bit only)
endpackage

// File: rtl/hpair_lane.sv
// One pair reduction at element width EW, optionally saturating.
module hpair_lane #(
   parameter int EW     = 16,
   parameter bit SAT_EN = 1'b0
) (
   input  logic [EW-1:0] x_even,
   input  logic [EW-1:0] x_odd,
   input  logic          sub,
   input  logic          sat,
   output logic [EW-1:0] y
);
   logic [EW:0] ext_e;
   logic [EW:0] ext_o;
   logic [EW:0] full;

   assign ext_e = {x_even[EW-1], x_even};
   assign ext_o = {x_odd[EW-1], x_odd};
   assign full  = sub ? (ext_e - ext_o) : (ext_e + ext_o);

   if (SAT_EN) begin : g_sat
      logic ovf;
      assign ovf = full[EW] ^ full[EW-1];
      always_comb begin
         if (sat && ovf)
            y = full[EW] ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
         else
            y = full[EW-1:0];
      end
   end else begin : g_wrap
      logic unused_sat;
      assign unused_sat = sat;
      assign y          = full[EW-1:0];
   end
endmodule

// File: rtl/hpair_stage.sv
// All pair lanes for one element width; A results low, B results high.
module hpair_stage #(
   parameter int VEC_W  = 128,
   parameter int EW     = 16,
   parameter bit SAT_EN = 1'b0
) (
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             sub,
   input  logic             sat,
   output logic [VEC_W-1:0] y
);
   localparam int NE = VEC_W / EW;
   localparam int NP = NE / 2;

   for (genvar s = 0; s < 2; s++) begin : g_src
      logic [VEC_W-1:0] v;
      assign v = (s == 0) ? src_a : src_b;
      for (genvar k = 0; k < NP; k++) begin : g_pair
         hpair_lane #(.EW(EW), .SAT_EN(SAT_EN)) i_lane (
            .x_even (v[(2*k)*EW +: EW]),
            .x_odd  (v[(2*k+1)*EW +: EW]),
            .sub    (sub),
            .sat    (sat),
            .y      (y[(s*NP+k)*EW +: EW])
         );
      end
   end
endmodule

// File: rtl/hpair_addsub.sv
module hpair_addsub
   import hpair_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int WORD_W  = 16,
   parameter int DWORD_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OP_W-1:0]  req_op,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic             res_valid,
   output logic [VEC_W-1:0] res_data
);
   localparam int PAIR_DW = 2 * DWORD_W;

   if ((VEC_W % PAIR_DW) != 0 || (VEC_W % (2 * WORD_W)) != 0) begin : g_bad_width
      $error("hpair_addsub: VEC_W must hold whole element pairs");
   end
   if (WORD_W < 2 || DWORD_W <= WORD_W) begin : g_bad_elem
      $error("hpair_addsub: element widths out of order");
   end

   logic [VEC_W-1:0] word_res;
   logic [VEC_W-1:0] dword_res;
   logic [VEC_W-1:0] sel_res;

   hpair_stage #(.VEC_W(VEC_W), .EW(WORD_W), .SAT_EN(1'b1)) i_word (
      .src_a (src_a),
      .src_b (src_b),
      .sub   (req_op[OP_SUB_BIT]),
      .sat   (req_op[OP_SAT_BIT]),
      .y     (word_res)
   );

   // Saturation is never applied to doublewords.
   hpair_stage #(.VEC_W(VEC_W), .EW(DWORD_W), .SAT_EN(1'b0)) i_dword (
      .src_a (src_a),
      .src_b (src_b),
      .sub   (req_op[OP_SUB_BIT]),
      .sat   (1'b0),
      .y     (dword_res)
   );

   assign sel_res = req_op[OP_DW_BIT] ? dword_res : word_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) res_data <= sel_res;
      end
   end
endmodule

// File: rtl/hpair_addsub_chk.sv
module hpair_addsub_chk #(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       req_op,
   input logic [VEC_W-1:0] src_a,
   input logic [VEC_W-1:0] src_b,
   input logic             res_valid,
   input logic [VEC_W-1:0] res_data
);
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!res_valid && res_data == '0));

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_data));

   // Two non-negative words added with clamping never give a negative lane 0.
   p_sat_add_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'b100 && !src_a[15] && !src_a[31])
      |=> !res_data[15]);

   // Non-negative minus negative with clamping never gives a negative lane 0.
   p_sat_sub_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'b101 && !src_a[15] && src_a[31])
      |=> !res_data[15]);
endmodule

bind hpair_addsub hpair_addsub_chk #(.VEC_W(VEC_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .src_a     (src_a),
   .src_b     (src_b),
   .res_valid (res_valid),
   .res_data  (res_data)
);

// File: tb/test_hpair_addsub.sv
`timescale 1ns/1ps
module test_hpair_addsub;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [2:0]   req_op = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         res_valid;
   logic [127:0] res_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   hpair_addsub i_hpair_addsub (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data)
   );

   function automatic logic [127:0] model(logic [2:0] op, logic [127:0] a, logic [127:0] b);
      logic [127:0] r = '0;
      for (int s = 0; s < 2; s++) begin
         logic [127:0] v = (s == 0) ? a : b;
         if (!op[1]) begin
            for (int k = 0; k < 4; k++) begin
               int e = $signed(v[32*k +: 16]);
               int o = $signed(v[32*k+16 +: 16]);
               int t = op[0] ? e - o : e + o;
               if (op[2]) begin
                  if (t > 32767) t = 32767;
                  if (t < -32768) t = -32768;
               end
               r[(s*4+k)*16 +: 16] = t[15:0];
            end
         end else begin
            for (int k = 0; k < 2; k++) begin
               longint e = $signed(v[64*k +: 32]);
               longint o = $signed(v[64*k+32 +: 32]);
               longint t = op[0] ? e - o : e + o;
               r[(s*2+k)*32 +: 32] = t[31:0];
            end
         end
      end
      return r;
   endfunction

   function automatic string req_of(logic [2:0] op);
      case (op)
         3'b000: return "R4";
         3'b001: return "R5";
         3'b010: return "R6";
         3'b011: return "R7";
         3'b100, 3'b101: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one request, sample just after the edge that loads it.
   task automatic issue(logic [2:0] op, logic [127:0] a, logic [127:0] b, string req);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; src_a = a; src_b = b;
      @(posedge clk); #1;
      check("R2", {127'd0, res_valid}, 128'd1);
      check(req, res_data, model(op, a, b));
   endtask

   task automatic idle(logic [127:0] a);
      logic [127:0] held;
      held = res_data;
      @(negedge clk);
      req_valid = 1'b0; req_op = 3'b000; src_a = a; src_b = ~a;
      @(posedge clk); #1;
      check("R2", {127'd0, res_valid}, 128'd0);
      check("R3", res_data, held);
   endtask

   function automatic logic [15:0] pick_word();
      if ($urandom_range(1, 0) == 0) return 16'($urandom());
      case ($urandom_range(5, 0))
         0: return 16'h7FFF;
         1: return 16'h8000;
         2: return 16'h0001;
         3: return 16'hFFFF;
         4: return 16'h0000;
         default: return 16'h8001;
      endcase
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      #1;
      check("R1", {127'd0, res_valid}, 128'd0);
      check("R1", res_data, 128'd0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", {127'd0, res_valid}, 128'd0);
      check("R1", res_data, 128'd0);

      // Word wrap / saturation edges in lane 0 of A and lane 0 of B.
      issue(3'b000, {96'd0, 16'h0001, 16'h7FFF}, 128'd0, "R4");
      check("R4", res_data[15:0], 16'h8000);
      issue(3'b100, {96'd0, 16'h0001, 16'h7FFF}, 128'd0, "R8");
      check("R8", res_data[15:0], 16'h7FFF);
      issue(3'b100, {96'd0, 16'h8000, 16'h8000}, {96'd0, 16'hFFFF, 16'h8000}, "R8");
      check("R8", {res_data[79:64], res_data[15:0]}, {16'h8000, 16'h8000});
      issue(3'b001, {96'd0, 16'h0001, 16'h8000}, 128'd0, "R5");
      check("R5", res_data[15:0], 16'h7FFF);
      issue(3'b101, {96'd0, 16'h0001, 16'h8000}, {96'd0, 16'h8000, 16'h7FFF}, "R8");
      check("R8", {res_data[79:64], res_data[15:0]}, {16'h7FFF, 16'h8000});
      issue(3'b100, {96'd0, 16'h0000, 16'h7FFF}, {96'd0, 16'hFFFF, 16'h8001}, "R8");
      check("R8", {res_data[79:64], res_data[15:0]}, {16'h8000, 16'h7FFF});
      idle(128'h5A5A);

      // Doubleword edges, with and without the saturate bit.
      issue(3'b010, {64'd0, 32'h0000_0001, 32'h7FFF_FFFF}, 128'd0, "R6");
      check("R6", res_data[31:0], 32'h8000_0000);
      issue(3'b110, {64'd0, 32'h0000_0001, 32'h7FFF_FFFF}, 128'd0, "R9");
      check("R9", res_data[31:0], 32'h8000_0000);
      issue(3'b011, 128'd0, {64'd0, 32'h0000_0001, 32'h8000_0000}, "R7");
      check("R7", res_data[95:64], 32'h7FFF_FFFF);
      issue(3'b111, 128'd0, {64'd0, 32'h0000_0001, 32'h8000_0000}, "R9");
      check("R9", res_data[95:64], 32'h7FFF_FFFF);

      // Placement: A-only operands fill the low half, B-only the high half.
      issue(3'b000, 128'h0008_0007_0006_0005_0004_0003_0002_0001, 128'd0, "R10");
      check("R10", res_data, {64'd0, 16'd15, 16'd11, 16'd7, 16'd3});
      issue(3'b010, 128'd0, 128'h0000_0004_0000_0003_0000_0002_0000_0001, "R10");
      check("R10", res_data, {32'd7, 32'd3, 64'd0});
      idle(128'hDEAD);

      // Random phase with idle gaps.
      for (int i = 0; i < 600; i++) begin
         logic [127:0] a;
         logic [127:0] b;
         logic [2:0]   op;
         for (int w = 0; w < 8; w++) begin
            a[16*w +: 16] = pick_word();
            b[16*w +: 16] = pick_word();
         end
         op = 3'($urandom_range(7, 0));
         issue(op, a, b, req_of(op));
         if ($urandom_range(3, 0) == 0) idle(a ^ b);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule